// File: doc/BRIEF.md
# Queued Asynchronous Serial Transmitter

This block turns 9-bit words into asynchronous serial frames on a single output line. Words enter through a valid/ready write port into a 16-deep queue. A shift engine pulls words out of the queue one at a time and sends them using a tick input that pulses sixteen times per bit period. The frame layout (data width, parity, ninth bit) comes from a 3-bit format field. The same field encoding is used by the matching receiver, so both ends agree on the layout. A 2-bit field picks the stop length in half-bit steps.

The host sees three queue flags: empty, half-empty and full. A run input and an optional clear-to-send gate decide when a new frame may begin. A flush strobe empties the queue. The write port applies back-pressure with `wr_ready`, which is low exactly while the queue is full. A beat offered while `wr_ready` is low is not taken and changes nothing. The host must keep `wr_valid` asserted until it sees `wr_ready` high at a clock edge. The serial side has no back-pressure other than the run and clear-to-send gates.

Top module: `uart_tx_queue`

## Requirements
- R1: After reset the line is high, `tx_empty`=1, `tx_half_empty`=1, `tx_full`=0 and `wr_ready`=1. The line stays high whenever no frame is in progress.
- R2: A frame is a low start bit, then the payload bits least significant first, then the stop time at high level. Each start and payload bit lasts 16 ticks of `tick16`.
- R3: The `fmt` encoding selects the payload:
  - 3'b011: `wr_data[6:0]` followed by a parity bit.
  - 3'b111: `wr_data[7:0]` followed by a parity bit.
  - 3'b100 and 3'b101: all nine bits `wr_data[8:0]`, where bit 8 is the ninth bit sent.
  - 3'b001 and every other code: `wr_data[7:0]` with no parity bit.
- R4: With `par_odd`=0 the parity bit makes the count of ones in data plus parity even. With `par_odd`=1 it makes that count odd.
- R5: `stop_len` 0, 1, 2 and 3 give 8, 16, 24 and 32 ticks of stop time. Back-to-back frames are separated by exactly that many ticks of high level.
- R6: The queue holds 16 words and sends them in write order. `wr_ready` is `!tx_full`. A beat offered while the queue is full is dropped, and the queue contents are unchanged.
- R7: `tx_full` is 1 when 16 words are queued. `tx_half_empty` is 1 when at most 8 words are queued. `tx_empty` is 1 only when the queue is empty and the last stop time has ended.
- R8: With `cts_en`=1 a frame starts only while `cts` is 1. Dropping `cts` does not cut short a frame already in progress. With `cts_en`=0 the `cts` input has no effect.
- R9: While `run`=0 no frame starts, and queued words stay queued.
- R10: A one-cycle `tx_flush` pulse discards every queued word. A frame already in progress finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling tick, 16 per bit period |
| wr_valid | input | 1 | Write beat offered |
| wr_data | input | 9 | Word to queue |
| wr_ready | output | 1 | Queue can take a word |
| fmt | input | 3 | Frame format select |
| stop_len | input | 2 | Stop length select |
| par_odd | input | 1 | Odd parity when 1 |
| cts_en | input | 1 | Enable clear-to-send gating |
| cts | input | 1 | Clear-to-send, active high |
| run | input | 1 | Allow new frames to start |
| tx_flush | input | 1 | Discard queued words |
| tx_line | output | 1 | Serial output, idle high |
| tx_empty | output | 1 | Queue empty and line idle |
| tx_half_empty | output | 1 | At most half the queue is used |
| tx_full | output | 1 | Queue full |

## Verification
A corrupted queue pointer or count shows up within one frame time as a wrong or repeated word on the line. It also shows up at once as a wrong flag, because each queued word moves the count by one. A shift engine stuck busy holds `tx_empty` low and blocks the next start, so the stop-gap measurement between back-to-back frames exposes it. A tick counter that is off by one stretches or shrinks the bit time, and mid-bit sampling or the stop-gap tick count catches that within the first frame. A gate that leaks a start past `run` or `cts` puts a low start bit on the line during a window where the bench expects a steady high level.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

  localparam int FRAME_W = 10;  // start bit plus up to nine payload bits
  localparam int WORD_W  = 9;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_STOP} tx_state_e;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;  // bit 0 goes out first (start bit)
    logic [3:0]         len;   // number of bits before the stop time
  } frame_t;

  // Lay out start bit and payload for one word according to the format code.
  function automatic frame_t build_frame(input logic [2:0] fmt,
                                         input logic par_odd,
                                         input logic [WORD_W-1:0] d);
    frame_t f;
    case (fmt)
      3'b011: begin
        f.bits = {1'b1, (^d[6:0]) ^ par_odd, d[6:0], 1'b0};
        f.len  = 4'd9;
      end
      3'b111: begin
        f.bits = {(^d[7:0]) ^ par_odd, d[7:0], 1'b0};
        f.len  = 4'd10;
      end
      3'b100, 3'b101: begin
        f.bits = {d[8:0], 1'b0};
        f.len  = 4'd10;
      end
      default: begin
        f.bits = {1'b1, d[7:0], 1'b0};
        f.len  = 4'd9;
      end
    endcase
    return f;
  endfunction

endpackage

// File: rtl/uatx_fifo.sv
module uatx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 9,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);

  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign push_ok = push && (count != CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  // R6: occupancy never exceeds the queue size
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R6: a beat offered to a full queue leaves the occupancy at full
  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && push && !pop && !flush) |=> count == CW'(DEPTH));

  // R7: the consumer never takes a word from an empty queue
  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);

endmodule

// File: rtl/uatx_shifter.sv
module uatx_shifter
  import uatx_pkg::*;
#(
  parameter int BIT_TICKS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_bits,
  input  logic [3:0]         frame_len,
  input  logic [1:0]         stop_sel,
  output logic               line,
  output logic               busy
);

  localparam int HALF = BIT_TICKS / 2;
  localparam int TW   = $clog2(2 * BIT_TICKS);

  tx_state_e          st;
  logic [FRAME_W-1:0] sh;
  logic [3:0]         bits_left;
  logic [TW-1:0]      tcnt;
  logic [1:0]         stop_q;
  logic [TW-1:0]      stop_end;

  assign stop_end = TW'((int'(stop_q) + 1) * HALF - 1);
  assign line     = (st == ST_DATA) ? sh[0] : 1'b1;
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sh        <= '1;
      bits_left <= '0;
      tcnt      <= '0;
      stop_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (load) begin
            st        <= ST_DATA;
            sh        <= frame_bits;
            bits_left <= frame_len - 4'd1;
            tcnt      <= '0;
            stop_q    <= stop_sel;
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (tcnt == TW'(BIT_TICKS - 1)) begin
              tcnt <= '0;
              if (bits_left == '0) begin
                st <= ST_STOP;
              end else begin
                sh        <= {1'b1, sh[FRAME_W-1:1]};
                bits_left <= bits_left - 4'd1;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (tcnt == stop_end) begin
              tcnt <= '0;
              st   <= ST_IDLE;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: a new frame is only loaded when the engine is idle
  p_load_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> st == ST_IDLE);

  // R2: without a tick the bit on the line cannot move
  p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && !tick) |=> $stable(sh) && $stable(st));

  // R5: the stop time always hands back to idle, never to data
  p_stop_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP) |=> (st != ST_DATA));

endmodule

// File: rtl/uart_tx_queue.sv
module uart_tx_queue
  import uatx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int BIT_TICKS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic        wr_valid,
  input  logic [8:0]  wr_data,
  output logic        wr_ready,
  input  logic [2:0]  fmt,
  input  logic [1:0]  stop_len,
  input  logic        par_odd,
  input  logic        cts_en,
  input  logic        cts,
  input  logic        run,
  input  logic        tx_flush,
  output logic        tx_line,
  output logic        tx_empty,
  output logic        tx_half_empty,
  output logic        tx_full
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]     count;
  logic [WORD_W-1:0] head;
  logic              busy;
  logic              start;
  logic              gate_ok;
  frame_t            frame;

  assign tx_full       = (count == CW'(DEPTH));
  assign tx_half_empty = (count <= CW'(DEPTH / 2));
  assign wr_ready      = !tx_full;
  assign tx_empty      = (count == '0) && !busy;

  assign gate_ok = run && (!cts_en || cts);
  assign start   = !busy && (count != '0) && gate_ok && !tx_flush;
  assign frame   = build_frame(fmt, par_odd, head);

  uatx_fifo #(.DEPTH(DEPTH), .W(WORD_W), .CW(CW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_flush),
    .push  (wr_valid && wr_ready),
    .pop   (start),
    .wdata (wr_data),
    .rdata (head),
    .count (count)
  );

  uatx_shifter #(.BIT_TICKS(BIT_TICKS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .load       (start),
    .frame_bits (frame.bits),
    .frame_len  (frame.len),
    .stop_sel   (stop_len),
    .line       (tx_line),
    .busy       (busy)
  );

  // R8: a frame begins only while clear-to-send permits it
  p_cts_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> ($past(cts) || !$past(cts_en)));

  // R9: a frame begins only while run is set
  p_run_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> $past(run));

  // R7: an empty transmitter always shows an idle line
  p_empty_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_line);

endmodule

// File: tb/uart_tx_queue_tb_top.sv
module uart_tx_queue_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       wr_valid = 1'b0;
  logic [8:0] wr_data = '0;
  logic       wr_ready;
  logic [2:0] fmt = 3'b001;
  logic [1:0] stop_len = 2'd1;
  logic       par_odd = 1'b0;
  logic       cts_en = 1'b0;
  logic       cts = 1'b0;
  logic       run = 1'b0;
  logic       tx_flush = 1'b0;
  logic       tx_line, tx_empty, tx_half_empty, tx_full;

  int total = 0;
  int bad = 0;
  bit pending_low = 0;

  uart_tx_queue dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .fmt(fmt), .stop_len(stop_len), .par_odd(par_odd),
    .cts_en(cts_en), .cts(cts), .run(run), .tx_flush(tx_flush),
    .tx_line(tx_line), .tx_empty(tx_empty),
    .tx_half_empty(tx_half_empty), .tx_full(tx_full)
  );

  always #5 clk = ~clk;

  // tick every second clock, changed just after a rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1 tick16 = ~tick16;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void exp_frame(input logic [2:0] m, input logic odd,
                                    input logic [8:0] d,
                                    output logic [9:0] b, output int len);
    int ones;
    ones = 0;
    b = '1;
    b[0] = 1'b0;
    if (m == 3'b011) begin
      for (int i = 0; i < 7; i++) begin b[i+1] = d[i]; ones += int'(d[i]); end
      b[8] = ((ones % 2) == 1) ^ odd;
      len = 9;
    end else if (m == 3'b111) begin
      for (int i = 0; i < 8; i++) begin b[i+1] = d[i]; ones += int'(d[i]); end
      b[9] = ((ones % 2) == 1) ^ odd;
      len = 10;
    end else if (m == 3'b100 || m == 3'b101) begin
      for (int i = 0; i < 9; i++) b[i+1] = d[i];
      len = 10;
    end else begin
      for (int i = 0; i < 8; i++) b[i+1] = d[i];
      len = 9;
    end
  endfunction

  task automatic sample_tick(output logic v);
    do @(negedge clk); while (!tick16);
    v = tx_line;
  endtask

  task automatic put(input logic [8:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic flush_q();
    tx_flush = 1'b1;
    @(posedge clk);
    #1 tx_flush = 1'b0;
  endtask

  // Decode one frame of len bits; count high samples afterwards up to limit.
  task automatic recv(input int len, input int limit, output logic [9:0] b, output int hi);
    logic v;
    b = '1;
    if (!pending_low) begin
      do sample_tick(v); while (v == 1'b1);
    end
    pending_low = 0;
    for (int idx = 1; idx < 16 * len; idx++) begin
      sample_tick(v);
      if (idx % 16 == 8) b[idx/16] = v;
    end
    b[0] = 1'b0;
    hi = 0;
    while (hi < limit) begin
      sample_tick(v);
      if (v == 1'b0) begin
        pending_low = 1;
        break;
      end
      hi++;
    end
  endtask

  task automatic quiet_ticks(input int n, input string req);
    logic v;
    int lows;
    lows = 0;
    for (int i = 0; i < n; i++) begin
      sample_tick(v);
      if (v == 1'b0) lows++;
    end
    check(lows == 0, req, lows, 0);
  endtask

  initial begin
    logic [9:0] got, exp;
    int len, hi, n;
    logic [8:0] words [16];
    int seed;

    seed = $urandom(32'd20240611);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check(tx_line == 1'b1, "R1 line idle", tx_line, 1);
    check(tx_empty == 1'b1, "R1 empty", tx_empty, 1);
    check(tx_half_empty == 1'b1, "R1 half", tx_half_empty, 1);
    check(tx_full == 1'b0, "R1 full", tx_full, 0);
    check(wr_ready == 1'b1, "R1 ready", wr_ready, 1);
    @(posedge clk); #1;

    // R6/R7/R9: fill to full with run low, overflow beat dropped
    run = 1'b0; fmt = 3'b001; stop_len = 2'd1;
    for (int i = 0; i < 16; i++) begin
      words[i] = 9'((i * 37 + 5) & 9'h0FF);
      put(words[i]);
      @(negedge clk);
      if (i == 7) check(tx_half_empty == 1'b1, "R7 half at 8", tx_half_empty, 1);
      if (i == 8) check(tx_half_empty == 1'b0, "R7 half at 9", tx_half_empty, 0);
      if (i == 14) check(tx_full == 1'b0, "R7 full at 15", tx_full, 0);
      @(posedge clk); #1;
    end
    @(negedge clk);
    check(tx_full == 1'b1, "R7 full at 16", tx_full, 1);
    check(wr_ready == 1'b0, "R6 ready low when full", wr_ready, 0);
    check(tx_empty == 1'b0, "R7 not empty", tx_empty, 0);
    @(posedge clk); #1;
    put(9'h1AA);
    quiet_ticks(40, "R9 no start while run low");
    run = 1'b1;
    for (int i = 0; i < 16; i++) begin
      exp_frame(fmt, par_odd, words[i], exp, len);
      recv(len, 40, got, hi);
      check(got == exp, "R6 order/data", int'(got), int'(exp));
      if (i < 15) check(hi == 16, "R5 one-bit stop gap", hi, 16);
      else check(hi == 40, "R6 dropped beat not sent", hi, 40);
    end
    @(negedge clk);
    check(tx_empty == 1'b1, "R7 empty after drain", tx_empty, 1);
    @(posedge clk); #1;

    // R7: empty stays low through the stop time
    stop_len = 2'd3; fmt = 3'b001;
    put(9'h0F0);
    begin
      logic v;
      do sample_tick(v); while (v == 1'b1);
      for (int i = 1; i < 16 * 9 + 4; i++) sample_tick(v);
      check(tx_empty == 1'b0, "R7 empty low in stop", tx_empty, 0);
      for (int i = 0; i < 40; i++) sample_tick(v);
      check(tx_empty == 1'b1, "R7 empty after stop", tx_empty, 1);
    end
    @(posedge clk); #1;

    // R10: flush discards queued words
    run = 1'b0;
    for (int i = 0; i < 5; i++) put(9'(i + 1));
    flush_q();
    @(negedge clk);
    check(tx_empty == 1'b1, "R10 empty after flush", tx_empty, 1);
    check(tx_half_empty == 1'b1, "R10 half after flush", tx_half_empty, 1);
    check(tx_full == 1'b0, "R10 full after flush", tx_full, 0);
    @(posedge clk); #1;
    run = 1'b1;
    quiet_ticks(60, "R10 nothing sent after flush");

    // R8: clear-to-send gating
    run = 1'b0; cts_en = 1'b1; cts = 1'b0; fmt = 3'b100; stop_len = 2'd1;
    put(9'h155); put(9'h0AB);
    run = 1'b1;
    quiet_ticks(100, "R8 held by cts low");
    @(negedge clk);
    check(tx_empty == 1'b0, "R8 words kept", tx_empty, 0);
    @(posedge clk); #1;
    cts = 1'b1;
    while (tx_line == 1'b1) @(negedge clk);
    cts = 1'b0;
    pending_low = 1;
    exp_frame(fmt, par_odd, 9'h155, exp, len);
    recv(len, 60, got, hi);
    check(got == exp, "R8 frame finishes after cts drop", int'(got), int'(exp));
    check(hi == 60, "R8 second frame held", hi, 60);
    @(posedge clk); #1;
    cts = 1'b1;
    exp_frame(fmt, par_odd, 9'h0AB, exp, len);
    recv(len, 40, got, hi);
    check(got == exp, "R3 ninth bit frame", int'(got), int'(exp));
    cts_en = 1'b0; cts = 1'b0;
    @(posedge clk); #1;

    // R2/R3/R4/R5: random formats, stop lengths and parity
    for (int r = 0; r < 8; r++) begin
      logic [2:0] fl [6];
      fl[0] = 3'b001; fl[1] = 3'b011; fl[2] = 3'b111;
      fl[3] = 3'b100; fl[4] = 3'b101; fl[5] = 3'b000;
      run = 1'b0;
      flush_q();
      fmt = (r < 6) ? fl[r] : fl[$urandom % 6];
      stop_len = 2'($urandom % 4);
      par_odd = 1'($urandom % 2);
      n = 2 + int'($urandom % 5);
      for (int i = 0; i < n; i++) begin
        words[i] = 9'($urandom);
        put(words[i]);
      end
      run = 1'b1;
      for (int i = 0; i < n; i++) begin
        exp_frame(fmt, par_odd, words[i], exp, len);
        recv(len, 40, got, hi);
        check(got == exp, "R3 R4 frame content", int'(got), int'(exp));
        if (i < n - 1)
          check(hi == (int'(stop_len) + 1) * 8, "R5 stop gap", hi, (int'(stop_len) + 1) * 8);
        else
          check(hi == 40, "R2 idle after last frame", hi, 40);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule